// File: doc/BRIEF.md
# Analog Channel Scan Sequencer

This block is the digital front end of a successive-approximation converter. Software picks channels through a two-word enable mask and writes the run bit. The sequencer then converts every enabled channel, lowest number first. For each channel it presents the channel number with a one-cycle start pulse and waits for the core's done pulse and result. Each result lands in a per-channel result register. A scan runs one pass and stops by itself, or it wraps to the lowest enabled channel and repeats until software clears the run bit.

Each result can be tested against a programmable 12-bit upper limit, lower limit or both. When a test matches, the block sets a sticky per-channel flag, and the interrupt holds high until software clears every flag. When limit testing is off, the interrupt is a one-cycle pulse, either after every conversion or once per completed pass.

The controller has three states. ST_IDLE waits for the run bit and, when it is set, moves to ST_ISSUE (the go transition). ST_ISSUE drives the start pulse and always moves to ST_WAIT (the issue transition). ST_WAIT holds until done arrives. On done it takes one of three transitions: the advance transition to ST_ISSUE with the next higher enabled channel, the wrap transition to ST_ISSUE with the lowest enabled channel (loop mode), or the finish transition to ST_IDLE, which clears the run bit. A write that clears the run bit takes the abort transition from any state to ST_IDLE.

Top module: `adc_scan_seq`

## Requirements
- R1: Channel enables for channels 0 to 15 are bits 15:0 of register 0, and enables for channels 16 and 17 are bits 1:0 of register 1. Unused bits read back as 0.
- R2: Enabled channels are converted in ascending order. Each conversion is a one-cycle `conv_start` with `conv_ch`, and no new start is issued until `conv_done` arrives.
- R3: Writing the run bit (register 2 bit 0) as 1 while every enable bit is 0 leaves the run bit at 0 and issues no start.
- R4: With the loop bit (register 2 bit 1) at 0, a run performs exactly one pass over the enabled channels and then the run bit reads 0.
- R5: With the loop bit at 1, the channel after the highest enabled one is the lowest enabled one, and the run bit stays 1.
- R6: Writing register 2 with the run bit at 0 stops the scan. The run bit reads 0 and no further start is issued.
- R7: The latest result of channel n reads back at address 32+n, zero-extended.
- R8: With the limit-enable bit (register 2 bit 3) at 1, a result sets the flag of its channel when it matches the condition in register 2 bits 5:4. Code 0 matches result > upper (register 3). Code 1 matches result < lower (register 4). Codes 2 and 3 match either case. Comparisons are unsigned. The flags read at register 5 (channels 0 to 15) and register 6 bits 1:0 (channels 16 and 17).
- R9: A flag stays set until a whole-word write to its flag register carries a 1 in its bit. Bits written as 0 are unchanged. With limit enable on, `irq` is high exactly while any flag is set.
- R10: With limit enable off, `irq` pulses for one cycle per conversion when register 2 bit 2 is 0, and once per completed pass when it is 1.
- R11: With limit enable on, register 2 bit 2 has no effect: no conversion and no pass end raises `irq` unless a flag is set.
- R12: After reset, all registers, flags and results read 0, and `irq` and `conv_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | 16 | Write data (whole word) |
| rd_addr | input | 6 | Read address |
| rd_data | output | 16 | Read data, combinational |
| conv_ch | output | 5 | Channel to convert |
| conv_start | output | 1 | One-cycle conversion request |
| conv_done | input | 1 | One-cycle completion from the core |
| conv_result | input | 12 | Conversion result, valid with conv_done |
| irq | output | 1 | Interrupt |

## Verification
The bench builds the block with its default parameters: 18 channels, 12-bit results, 16-bit register words and 6-bit addresses. With these values the enable and flag sets span two register words. Channels 16 and 17 therefore exercise the mapping into the second word, the top-end wrap in loop mode and the masking of unused high bits. The 12-bit limits let results near both ends of the range test each limit condition.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        LIM_ABOVE = 2'd0,
        LIM_BELOW = 2'd1,
        LIM_OUT_A = 2'd2,
        LIM_OUT_B = 2'd3
    } lim_cond_t;

    localparam int REG_ENA_LO   = 0;
    localparam int REG_ENA_HI   = 1;
    localparam int REG_CTRL     = 2;
    localparam int REG_UPPER    = 3;
    localparam int REG_LOWER    = 4;
    localparam int REG_STAT_LO  = 5;
    localparam int REG_STAT_HI  = 6;
    localparam int REG_RES_BASE = 32;

    localparam int CTRL_RUN      = 0;
    localparam int CTRL_LOOP     = 1;
    localparam int CTRL_SCAN_IRQ = 2;
    localparam int CTRL_LIM_EN   = 3;
    localparam int CTRL_COND_LSB = 4;

endpackage

// File: rtl/adc_seq_pick.sv
// Lowest set bit of mask at or above index 'from'.
module adc_seq_pick #(
    parameter int NCH = 18,
    parameter int CHW = $clog2(NCH)
) (
    input  logic [NCH-1:0] mask,
    input  logic [CHW:0]   from,
    output logic           found,
    output logic [CHW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i] && (i >= int'(from))) begin
                found = 1'b1;
                idx   = CHW'(i);
            end
        end
    end
endmodule

// File: rtl/adc_seq_limit.sv
module adc_seq_limit
    import adc_seq_pkg::*;
#(
    parameter int RW = 12
) (
    input  logic [RW-1:0] result,
    input  logic [RW-1:0] upper,
    input  logic [RW-1:0] lower,
    input  lim_cond_t     cond,
    output logic          match
);
    logic over, under;

    assign over  = result > upper;
    assign under = result < lower;

    always_comb begin
        case (cond)
            LIM_ABOVE: match = over;
            LIM_BELOW: match = under;
            default:   match = over | under;
        endcase
    end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int CHW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run_set,
    input  logic           run_clr,
    input  logic           loop_en,
    input  logic           conv_done,
    input  logic           first_found,
    input  logic [CHW-1:0] first_idx,
    input  logic           next_found,
    input  logic [CHW-1:0] next_idx,
    output logic           run,
    output logic [CHW-1:0] cur_ch,
    output logic           conv_start,
    output logic           accept,
    output logic           pass_end
);
    seq_state_t state;

    // State register and run flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            run    <= 1'b0;
            cur_ch <= '0;
        end else if (run_clr) begin
            state <= ST_IDLE;
            run   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (run) begin
                        if (first_found) begin
                            state  <= ST_ISSUE;
                            cur_ch <= first_idx;
                        end else begin
                            run <= 1'b0;
                        end
                    end
                end
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: begin
                    if (conv_done) begin
                        if (next_found) begin
                            state  <= ST_ISSUE;
                            cur_ch <= next_idx;
                        end else if (loop_en && first_found) begin
                            state  <= ST_ISSUE;
                            cur_ch <= first_idx;
                        end else begin
                            state <= ST_IDLE;
                            run   <= 1'b0;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
            if (run_set) run <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        conv_start = (state == ST_ISSUE);
        accept     = (state == ST_WAIT) && conv_done;
        pass_end   = (state == ST_WAIT) && conv_done && !next_found;
    end

    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    assert_hold_until_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !conv_done) |=> !conv_start);

    assert_ascending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && next_found && !run_clr) |=> (cur_ch > $past(cur_ch)));

    assert_oneshot_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_end && !loop_en && !run_set && !run_clr) |=> !run);

    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_end && loop_en && first_found && !run_clr)
            |=> (conv_start && cur_ch == $past(first_idx)));

    assert_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_clr |=> (!run && !conv_start));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter int NCH = 18,
    parameter int RW  = 12,
    parameter int DW  = 16,
    parameter int AW  = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [DW-1:0]            wr_data,
    input  logic [AW-1:0]            rd_addr,
    output logic [DW-1:0]            rd_data,
    output logic [$clog2(NCH)-1:0]   conv_ch,
    output logic                     conv_start,
    input  logic                     conv_done,
    input  logic [RW-1:0]            conv_result,
    output logic                     irq
);
    localparam int CHW = $clog2(NCH);
    localparam int PAD = 2 * DW - NCH;   // NCH must stay below 2*DW

    logic [NCH-1:0] ena, lstat;
    logic [NCH-1:0] ena_we, ena_wd, st_clr, st_set;
    logic           loop_en, scan_irq, lim_en;
    lim_cond_t      cond;
    logic [RW-1:0]  upper, lower;
    logic [RW-1:0]  res_mem [NCH];
    logic           evt_q;

    logic ctrl_wr, ena_lo_wr, ena_hi_wr, up_wr, lo_wr, stat_lo_wr, stat_hi_wr;
    logic run_set, run_clr, run;
    logic first_found, next_found, accept, pass_end, lim_hit;
    logic [CHW-1:0] first_idx, next_idx, cur_ch;

    assign ctrl_wr    = wr_en && (wr_addr == AW'(REG_CTRL));
    assign ena_lo_wr  = wr_en && (wr_addr == AW'(REG_ENA_LO));
    assign ena_hi_wr  = wr_en && (wr_addr == AW'(REG_ENA_HI));
    assign up_wr      = wr_en && (wr_addr == AW'(REG_UPPER));
    assign lo_wr      = wr_en && (wr_addr == AW'(REG_LOWER));
    assign stat_lo_wr = wr_en && (wr_addr == AW'(REG_STAT_LO));
    assign stat_hi_wr = wr_en && (wr_addr == AW'(REG_STAT_HI));

    assign run_set = ctrl_wr && wr_data[CTRL_RUN] && (|ena);
    assign run_clr = ctrl_wr && !wr_data[CTRL_RUN];

    // Per-channel write enables and flag set/clear terms
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam int WORD = g / DW;
        localparam int BIT  = g % DW;
        assign ena_we[g] = (WORD == 0) ? ena_lo_wr : ena_hi_wr;
        assign ena_wd[g] = wr_data[BIT];
        assign st_clr[g] = ((WORD == 0) ? stat_lo_wr : stat_hi_wr) && wr_data[BIT];
        assign st_set[g] = accept && lim_en && lim_hit && (cur_ch == CHW'(g));
    end

    adc_seq_pick #(.NCH(NCH), .CHW(CHW)) u_first (
        .mask (ena),
        .from ('0),
        .found(first_found),
        .idx  (first_idx)
    );

    adc_seq_pick #(.NCH(NCH), .CHW(CHW)) u_next (
        .mask (ena),
        .from ({1'b0, cur_ch} + 1'b1),
        .found(next_found),
        .idx  (next_idx)
    );

    adc_seq_limit #(.RW(RW)) u_limit (
        .result(conv_result),
        .upper (upper),
        .lower (lower),
        .cond  (cond),
        .match (lim_hit)
    );

    adc_seq_fsm #(.CHW(CHW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_set    (run_set),
        .run_clr    (run_clr),
        .loop_en    (loop_en),
        .conv_done  (conv_done),
        .first_found(first_found),
        .first_idx  (first_idx),
        .next_found (next_found),
        .next_idx   (next_idx),
        .run        (run),
        .cur_ch     (cur_ch),
        .conv_start (conv_start),
        .accept     (accept),
        .pass_end   (pass_end)
    );

    assign conv_ch = cur_ch;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ena      <= '0;
            lstat    <= '0;
            loop_en  <= 1'b0;
            scan_irq <= 1'b0;
            lim_en   <= 1'b0;
            cond     <= LIM_ABOVE;
            upper    <= '0;
            lower    <= '0;
            evt_q    <= 1'b0;
            for (int i = 0; i < NCH; i++) res_mem[i] <= '0;
        end else begin
            ena   <= (ena & ~ena_we) | (ena_wd & ena_we);
            lstat <= (lstat & ~st_clr) | st_set;
            evt_q <= accept && (!scan_irq || pass_end);
            if (ctrl_wr) begin
                loop_en  <= wr_data[CTRL_LOOP];
                scan_irq <= wr_data[CTRL_SCAN_IRQ];
                lim_en   <= wr_data[CTRL_LIM_EN];
                cond     <= lim_cond_t'(wr_data[CTRL_COND_LSB +: 2]);
            end
            if (up_wr) upper <= wr_data[RW-1:0];
            if (lo_wr) lower <= wr_data[RW-1:0];
            if (accept) res_mem[cur_ch] <= conv_result;
        end
    end

    assign irq = lim_en ? (|lstat) : evt_q;

    // Read port
    logic [2*DW-1:0] ena_wide, stat_wide;
    logic [AW-1:0]   res_off;

    assign ena_wide  = {{PAD{1'b0}}, ena};
    assign stat_wide = {{PAD{1'b0}}, lstat};
    assign res_off   = rd_addr - AW'(REG_RES_BASE);

    always_comb begin
        rd_data = '0;
        if (rd_addr >= AW'(REG_RES_BASE) && res_off < AW'(NCH)) begin
            rd_data = DW'(res_mem[res_off[CHW-1:0]]);
        end else begin
            case (rd_addr)
                AW'(REG_ENA_LO):  rd_data = ena_wide[DW-1:0];
                AW'(REG_ENA_HI):  rd_data = ena_wide[2*DW-1:DW];
                AW'(REG_CTRL):    rd_data = DW'({cond, lim_en, scan_irq, loop_en, run});
                AW'(REG_UPPER):   rd_data = DW'(upper);
                AW'(REG_LOWER):   rd_data = DW'(lower);
                AW'(REG_STAT_LO): rd_data = stat_wide[DW-1:0];
                AW'(REG_STAT_HI): rd_data = stat_wide[2*DW-1:DW];
                default:          rd_data = '0;
            endcase
        end
    end

    assert_empty_refuse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wr_data[CTRL_RUN] && ena == '0 && !run) |=> !run);

    assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && lim_en && lim_hit) |=> lstat[$past(cur_ch)]);

    assert_stat_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_lo_wr && !stat_hi_wr) |=> ((lstat & $past(lstat)) == $past(lstat)));

    assert_scan_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !pass_end && !lim_en && scan_irq && !ctrl_wr) |=> !irq);
endmodule

// File: tb/adc_scan_seq_tb.sv
`timescale 1ns/1ps
module adc_scan_seq_tb;
    localparam int NCH = 18;

    typedef struct packed {
        logic [17:0] mask;
        logic        scan;
        logic        lim;
        logic [1:0]  cond;
        logic [11:0] upper;
        logic [11:0] lower;
        logic [11:0] base;
        logic [11:0] step;
        logic [4:0]  exp_conv;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{18'h00001, 1'b0, 1'b0, 2'd0, 12'd0,    12'd0,    12'd100,  12'd0,   5'd1},
        '{18'h30000, 1'b0, 1'b0, 2'd0, 12'd0,    12'd0,    12'd7,    12'd300, 5'd2},
        '{18'h2A5A5, 1'b1, 1'b0, 2'd0, 12'd0,    12'd0,    12'd4000, 12'd5,   5'd9},
        '{18'h3FFFF, 1'b0, 1'b1, 2'd0, 12'd2000, 12'd0,    12'd0,    12'd200, 5'd18},
        '{18'h0F0F0, 1'b0, 1'b1, 2'd1, 12'd0,    12'd1000, 12'd500,  12'd100, 5'd8},
        '{18'h15555, 1'b0, 1'b1, 2'd2, 12'd1500, 12'd600,  12'd100,  12'd150, 5'd9},
        '{18'h000FF, 1'b1, 1'b1, 2'd3, 12'd300,  12'd200,  12'd250,  12'd0,   5'd8}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [4:0]  conv_ch;
    logic        conv_start;
    logic        conv_done = 1'b0;
    logic [11:0] conv_result = '0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    int starts = 0;
    int irq_cnt = 0;
    int last_ch = -1;
    logic [17:0] mask_g = '0;
    logic [11:0] base_g = '0;
    logic [11:0] step_g = '0;

    always #4 clk = ~clk;

    adc_scan_seq u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .conv_ch(conv_ch), .conv_start(conv_start),
        .conv_done(conv_done), .conv_result(conv_result), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        rd_addr = 6'(a);
        #1 v = int'(rd_data);
    endtask

    function automatic int next_en(input logic [17:0] m, input int from);
        for (int i = from; i < NCH; i++) if (m[i]) return i;
        return -1;
    endfunction

    function automatic int model_res(input int ch);
        return (int'(base_g) + ch * int'(step_g)) % 4096;
    endfunction

    function automatic bit lim_match(input int r, input logic [1:0] c, input int up, input int lo);
        if (c == 2'd0) return r > up;
        if (c == 2'd1) return r < lo;
        return (r > up) || (r < lo);
    endfunction

    task automatic wait_idle(output bit ok);
        int v;
        ok = 1'b0;
        for (int k = 0; k < 2000; k++) begin
            rd(2, v);
            if (v[0] == 1'b0) begin ok = 1'b1; break; end
        end
    endtask

    // Converter core model: fixed latency, checks channel order
    initial begin
        int pend_ch;
        int pend_cnt;
        pend_ch = 0;
        pend_cnt = 0;
        forever begin
            @(negedge clk);
            conv_done = 1'b0;
            if (pend_cnt > 0) begin
                pend_cnt--;
                if (pend_cnt == 0) begin
                    conv_done   = 1'b1;
                    conv_result = 12'(model_res(pend_ch));
                end
            end else if (conv_start) begin
                int e;
                e = next_en(mask_g, last_ch + 1);
                if (e < 0) begin
                    e = next_en(mask_g, 0);
                    chk("R5 wrap to lowest channel", int'(conv_ch), e);
                end else begin
                    chk("R2 ascending channel order", int'(conv_ch), e);
                end
                last_ch  = int'(conv_ch);
                pend_ch  = int'(conv_ch);
                pend_cnt = 3;
                starts++;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (irq) irq_cnt++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R4 watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int v;
        int s0;
        int exp_lo;
        int exp_hi;
        bit ok;
        logic [17:0] exp_st;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state
        rd(2, v);  chk("R12 ctrl after reset", v, 0);
        rd(0, v);  chk("R12 enable after reset", v, 0);
        rd(5, v);  chk("R12 flags after reset", v, 0);
        rd(37, v); chk("R12 result after reset", v, 0);
        chk("R12 irq after reset", int'(irq), 0);
        chk("R12 start after reset", int'(conv_start), 0);

        // R1: enable mapping and unused bits
        wr(0, 16'h1234); rd(0, v); chk("R1 enable low word", v, 16'h1234);
        wr(1, 16'hFFFF); rd(1, v); chk("R1 enable high word masked", v, 16'h0003);

        // R3: empty mask refuses to start
        wr(0, 0); wr(1, 0);
        s0 = starts;
        wr(2, 16'h0001);
        rd(2, v); chk("R3 run stays 0 on empty mask", v & 1, 0);
        repeat (10) @(negedge clk);
        chk("R3 no start on empty mask", starts - s0, 0);

        // Vector table: one-shot passes
        for (int n = 0; n < NVEC; n++) begin
            vec_t t;
            t = VECS[n];
            wr(0, int'(t.mask[15:0]));
            wr(1, int'(t.mask[17:16]));
            wr(3, int'(t.upper));
            wr(4, int'(t.lower));
            wr(5, 16'hFFFF);
            wr(6, 16'h0003);
            mask_g = t.mask; base_g = t.base; step_g = t.step;
            last_ch = -1;
            s0 = starts;
            exp_st = '0;
            for (int c = 0; c < NCH; c++)
                if (t.mask[c] && t.lim && lim_match(model_res(c), t.cond, int'(t.upper), int'(t.lower)))
                    exp_st[c] = 1'b1;
            irq_cnt = 0;
            wr(2, (int'(t.cond) << 4) | (int'(t.lim) << 3) | (int'(t.scan) << 2) | 1);
            wait_idle(ok);
            chk("R4 run bit self-clears after pass", int'(ok), 1);
            chk("R4 conversions in one pass", starts - s0, int'(t.exp_conv));
            exp_lo = int'(exp_st[15:0]);
            exp_hi = int'(exp_st[17:16]);
            rd(5, v); chk("R8 flags low word", v, exp_lo);
            rd(6, v); chk("R8 flags high word", v, exp_hi);
            if (!t.lim) chk("R10 interrupt pulse count", irq_cnt, t.scan ? 1 : int'(t.exp_conv));
            else if (exp_st == '0) chk("R11 no interrupt without flags", irq_cnt, 0);
            else chk("R9 irq held while flag set", int'(irq), 1);
            for (int c = 0; c < NCH; c++) begin
                if (t.mask[c]) begin
                    rd(32 + c, v);
                    chk("R7 stored result", v, model_res(c));
                end
            end
        end

        // R9: whole-word write-one-to-clear, per bit
        wr(5, 16'hFFFF); wr(6, 16'h0003);
        wr(0, 16'h0001); wr(1, 16'h0003);
        wr(3, 10); wr(4, 0);
        mask_g = 18'h30001; base_g = 12'd100; step_g = 12'd0; last_ch = -1;
        wr(2, 16'h0009);
        wait_idle(ok);
        rd(5, v); chk("R9 flag low set", v, 1);
        rd(6, v); chk("R9 flag high set", v, 3);
        wr(5, 16'hFFFF);
        rd(5, v); chk("R9 low cleared by write", v, 0);
        rd(6, v); chk("R9 high untouched", v, 3);
        chk("R9 irq still high", int'(irq), 1);
        wr(6, 16'h0001);
        rd(6, v); chk("R9 zero bits unchanged", v, 2);
        chk("R9 irq with one flag", int'(irq), 1);
        wr(6, 16'h0002);
        rd(6, v); chk("R9 last flag cleared", v, 0);
        chk("R9 irq drops with no flags", int'(irq), 0);

        // R5 / R6: loop mode then stop
        wr(0, 16'h0003); wr(1, 16'h0002);
        mask_g = 18'h20003; last_ch = -1;
        s0 = starts;
        wr(2, 16'h0003);
        for (int k = 0; k < 500 && (starts - s0) < 7; k++) @(negedge clk);
        chk("R5 loop keeps scanning", int'((starts - s0) >= 7), 1);
        rd(2, v); chk("R5 run stays set in loop", v & 1, 1);
        wr(2, 16'h0000);
        rd(2, v); chk("R6 run cleared by write", v & 1, 0);
        s0 = starts;
        repeat (20) @(negedge clk);
        chk("R6 no start after stop", starts - s0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule